// File: doc/BRIEF.md
# Selectable Bit-Rate Clock Divider

This block produces the clock that drives an external PCM encoder at twice the wanted bit rate. It also provides an elapsed-time base that the encoder can sample into its bi-level channels. One binary counter, advanced by a fixed reference clock (10 kHz nominal), does both jobs. A 3-bit rate code, taken from the instruction code of the active sequence, selects one counter bit as a tap. That tap is registered and sent out as the encoder clock. The encoder's serial bit clock comes back into the block, is synchronised, and leaves as a one-cycle strobe per bit for the rest of the system.

A restart pulse marks the start of a new sequence. It clears the counter, so every stored frame can be referred back to that start. It also makes the new rate code take effect at once. Between restarts a change of rate code is held back until both the old tap and the new tap are at the start of a period. This keeps short pulses off the encoder clock.

The 24-bit counter state is presented as four 6-bit words, one word for each bi-level channel group. The slowest rate code, divide-by-256, gives the lowest nominal rate. The divide-by-32 tap, 312.5 Hz from the 10 kHz reference, gives the nominal 150 bit/s rate.

Top module: `bitrate_clkgen`

## Requirements
- R1: While rst_ni is low, enc_clk_o, bit_stb_o and time_words_o are all zero.
- R2: time_words_o advances by one on each reference clock edge, modulo 2^24. Bits [6k+5:6k] form time word k, with word 0 as the least significant, so a count of 100 reads as word 0 = 36 and word 1 = 1.
- R3: A restart_i that is high on an edge sets time_words_o to zero after that edge. Counting resumes by one on the next edge.
- R4: With an active rate code s (0 to 7), enc_clk_o equals bit s of the time base. Its high phase and its low phase each last 2^s reference cycles, which divides the reference by 2^(s+1). After a restart, enc_clk_o starts low.
- R5: Between restarts, a new rate_sel_i value takes effect only at the first edge after which time-base bits [m:0] are all zero, where m is the larger of the old code and the new code. Until then enc_clk_o follows the old tap. After it, enc_clk_o follows the new tap. Every phase that is not cut by a restart lasts the full 2^s cycles of the code in force.
- R6: On a restart edge, the rate_sel_i value present at that edge becomes the active code at once. From the following cycle, enc_clk_o follows bit s of the time base.
- R7: Each rising edge of bit_clk_i produces exactly one single-cycle bit_stb_o pulse, visible after the second reference edge that follows the change. Falling edges produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Sequence restart pulse; clears the time base |
| rate_sel_i | input | 3 | Rate code from the sequence instruction; tap s divides by 2^(s+1) |
| bit_clk_i | input | 1 | Bit clock returned from the encoder, asynchronous |
| enc_clk_o | output | 1 | Twice-bit-rate clock to the encoder |
| bit_stb_o | output | 1 | One-cycle strobe per rising edge of the bit clock |
| time_words_o | output | 24 | Time base as four packed 6-bit words, word 0 in bits [5:0] |

## Verification
The bench raises the rate code in the middle of a period, from 1 to 3, and then lowers it from 3 to 0. A design that switched at once, or that waited only for the old tap's boundary, would put short phases on the encoder clock. The bench catches this by comparing enc_clk_o against the predicted tap in every cycle. It applies a restart while a tap is high and changes the code in the same cycle. A design that ignored the code at restart, or kept counting, would give a first phase of the wrong length. Every rate code is measured for exact high and low phase lengths, which catches an off-by-one tap index. The bit-strobe tests hold the returned clock high and then low for several cycles, which exposes a level-sensitive strobe or a strobe on falling edges.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;
  localparam int unsigned TB_W_DEF    = 24;
  localparam int unsigned WORD_W_DEF  = 6;
  localparam int unsigned SEL_W_DEF   = 3;
  localparam int unsigned SYNC_W_DEF  = 2;
endpackage

// File: rtl/tb_counter.sv
module tb_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] cnt_q;

  assign nxt_o = clr_i ? '0 : cnt_q + 1'b1;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end
endmodule

// File: rtl/tap_mux.sv
module tap_mux #(
  parameter int unsigned W     = 24,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     nxt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o,
  output logic [SEL_W-1:0] act_o
);
  localparam int unsigned TAPS = 1 << SEL_W;

  logic [TAPS-1:0]  taps;
  logic [TAPS-1:0]  span;
  logic [SEL_W-1:0] hi, sel_d, act_q;
  logic             bound, clk_q;

  assign taps = nxt_i[TAPS-1:0];

  // switch only where both old and new tap start a period
  always_comb begin
    hi = (sel_i > act_q) ? sel_i : act_q;
    for (int i = 0; i < TAPS; i++) span[i] = (SEL_W'(i) <= hi);
    bound = ((taps & span) == '0);
    sel_d = bound ? sel_i : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      clk_q <= 1'b0;
    end else begin
      act_q <= sel_d;
      clk_q <= taps[sel_d];
    end
  end

  assign clk_o = clk_q;
  assign act_o = act_q;
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/bitrate_clkgen.sv
module bitrate_clkgen
  import bitrate_pkg::*;
#(
  parameter int unsigned TB_W   = TB_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF,
  parameter int unsigned SYNC_W = SYNC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             bit_clk_i,
  output logic             enc_clk_o,
  output logic             bit_stb_o,
  output logic [TB_W-1:0]  time_words_o
);
  localparam int unsigned N_WORDS = TB_W / WORD_W;

  logic [TB_W-1:0]  cnt, cnt_nxt;
  logic [SEL_W-1:0] act_sel;

  tb_counter #(.W(TB_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart_i),
    .cnt_o  (cnt),
    .nxt_o  (cnt_nxt)
  );

  tap_mux #(.W(TB_W), .SEL_W(SEL_W)) u_tap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (cnt_nxt),
    .sel_i  (rate_sel_i),
    .clk_o  (enc_clk_o),
    .act_o  (act_sel)
  );

  edge_sync #(.STAGES(SYNC_W)) u_bit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bit_clk_i),
    .rise_o (bit_stb_o)
  );

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    assign time_words_o[k*WORD_W +: WORD_W] = cnt[k*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/bitrate_clkgen_chk.sv
module bitrate_clkgen_chk #(
  parameter int unsigned TB_W  = 24,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic [SEL_W-1:0] rate_sel_i,
  input logic             enc_clk_o,
  input logic             bit_stb_o,
  input logic [TB_W-1:0]  time_words_o,
  input logic [SEL_W-1:0] act_sel
);
  logic             started, clean, enc_q;
  logic [15:0]      hold_q;
  logic [SEL_W-1:0] sel_q;
  logic             toggle;

  assign toggle = (enc_clk_o != enc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started <= 1'b0;
      clean   <= 1'b1;
      enc_q   <= 1'b0;
      hold_q  <= '0;
      sel_q   <= '0;
    end else begin
      started <= 1'b1;
      enc_q   <= enc_clk_o;
      sel_q   <= act_sel;
      hold_q  <= toggle ? 16'd1 : hold_q + 16'd1;
      if (restart_i)   clean <= 1'b0;
      else if (toggle) clean <= 1'b1;
    end
  end

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && !$past(restart_i) |-> time_words_o == TB_W'($past(time_words_o) + 1'b1));

  p_restart_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> time_words_o == '0);

  p_full_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && toggle && clean |-> hold_q == (16'd1 << sel_q));

  p_restart_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> act_sel == $past(rate_sel_i));

  p_single_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o);
endmodule

bind bitrate_clkgen bitrate_clkgen_chk #(.TB_W(TB_W), .SEL_W(SEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .restart_i    (restart_i),
  .rate_sel_i   (rate_sel_i),
  .enc_clk_o    (enc_clk_o),
  .bit_stb_o    (bit_stb_o),
  .time_words_o (time_words_o),
  .act_sel      (act_sel)
);

// File: tb/bitrate_clkgen_bench.sv
module bitrate_clkgen_bench;
  localparam int NV = 8;
  localparam logic [2:0] V_SEL  [NV] = '{3'd5, 3'd0, 3'd7, 3'd2, 3'd4, 3'd1, 3'd6, 3'd3};
  localparam int         V_HALF [NV] = '{32, 1, 128, 4, 16, 2, 64, 8};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        bit_clk = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic        enc, stb;
  logic [23:0] tw;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bitrate_clkgen u_bitrate_clkgen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .restart_i    (restart),
    .rate_sel_i   (sel),
    .bit_clk_i    (bit_clk),
    .enc_clk_o    (enc),
    .bit_stb_o    (stb),
    .time_words_o (tw)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_restart();
    restart = 1'b1;
    tick(1);
    restart = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int lo, hi, bad;
    logic [23:0] t;
    logic exp_b;
    int cnt;

    repeat (3) @(negedge clk);
    chk("R1 enc", {31'd0, enc}, 0);
    chk("R1 stb", {31'd0, stb}, 0);
    chk("R1 time", {8'd0, tw}, 0);
    rst_n = 1'b1;
    tick(10);
    chk("R2 free count", {8'd0, tw}, 10);

    // vector walk: R4 phase lengths per code
    for (int i = 0; i < NV; i++) begin
      sel = V_SEL[i];
      pulse_restart();
      lo = 0;
      while (enc == 1'b0 && lo < 600) begin lo++; tick(1); end
      hi = 0;
      while (enc == 1'b1 && hi < 600) begin hi++; tick(1); end
      chk($sformatf("R4 low sel=%0d", V_SEL[i]), lo, V_HALF[i]);
      chk($sformatf("R4 high sel=%0d", V_SEL[i]), hi, V_HALF[i]);
    end

    // R2 / R3
    pulse_restart();
    chk("R3 cleared", {8'd0, tw}, 0);
    tick(100);
    chk("R2 count", {8'd0, tw}, 100);
    chk("R2 word0", {26'd0, tw[5:0]}, 36);
    chk("R2 word1", {26'd0, tw[11:6]}, 1);
    pulse_restart();
    chk("R3 cleared again", {8'd0, tw}, 0);
    tick(1);
    chk("R3 resumes", {8'd0, tw}, 1);

    // R5 deferred switching, up then down
    sel = 3'd1;
    pulse_restart();
    tick(5);
    sel = 3'd3;
    bad = 0;
    for (int j = 0; j < 40; j++) begin
      tick(1);
      t = tw;
      exp_b = (t >= 24'd16) ? t[3] : t[1];
      if (enc !== exp_b) bad++;
    end
    chk("R5 up switch mismatches", bad, 0);
    sel = 3'd0;
    bad = 0;
    for (int j = 0; j < 20; j++) begin
      tick(1);
      t = tw;
      exp_b = (t >= 24'd48) ? t[0] : t[3];
      if (enc !== exp_b) bad++;
    end
    chk("R5 down switch mismatches", bad, 0);

    // R6 code taken at restart
    sel = 3'd2;
    pulse_restart();
    tick(5);
    chk("R6 mid high before restart", {31'd0, enc}, 1);
    sel = 3'd6;
    pulse_restart();
    bad = 0;
    for (int j = 0; j < 200; j++) begin
      if (enc !== tw[6]) bad++;
      tick(1);
    end
    chk("R6 new tap after restart", bad, 0);

    // R7 bit strobe
    bit_clk = 1'b1;
    tick(1);
    chk("R7 no strobe yet", {31'd0, stb}, 0);
    tick(1);
    chk("R7 strobe", {31'd0, stb}, 1);
    tick(1);
    chk("R7 strobe ends", {31'd0, stb}, 0);
    cnt = 0;
    for (int j = 0; j < 6; j++) begin tick(1); if (stb) cnt++; end
    chk("R7 held high no strobe", cnt, 0);
    bit_clk = 1'b0;
    cnt = 0;
    for (int j = 0; j < 6; j++) begin tick(1); if (stb) cnt++; end
    chk("R7 falling edge no strobe", cnt, 0);
    bit_clk = 1'b1;
    cnt = 0;
    for (int j = 0; j < 6; j++) begin tick(1); if (stb) cnt++; end
    chk("R7 one strobe per rise", cnt, 1);

    finish_run();
  end
endmodule